// File: doc/BRIEF.md
# Sentinel-Flagged Circular Record Log

This block keeps an append-only log of fixed-size records in an external byte-wide nonvolatile store. The store is split into equal records. Byte 0 of each record is a marker byte. The marker of record 0 serves as the reference. Any other record counts as occupied while its marker equals that reference. Because of this, wrapping the log around needs only one byte written: record 0 gets a new reference, and every older record becomes free at once without being rewritten.

A client issues append, read-latest, erase or no-op commands over a valid/ready handshake. The block has no stored pointer. On every append or read it scans the markers upward from record 1 to find the first free slot. It then writes the new record there, or returns the record just below it. A done pulse marks completion. An empty flag reports a read on a log that holds nothing. All memory traffic is one byte at a time. Each byte waits for the store's ready signal.

Top module: `ring_log`

## Requirements
- R1: With the default sizes the store has 1024 bytes, records are 8 bytes and there are 128 records. Record i has its marker at address i*8. Payload byte j (bits 8j+7:8j of the payload vector) sits at address i*8+1+j.
- R2: When record 0's marker is 0xFF the log is fresh. A read completes with empty=1. An append writes record 0 with marker 0x80 and the payload.
- R3: When record 0's marker is not 0xFF, an append goes to the lowest record index i≥1 whose marker differs from record 0's marker. It writes that same marker value and the payload, and it changes no other byte of the store.
- R4: When every record's marker equals record 0's marker, an append goes to record 0. The new marker is 0x00 if the old one was 0x80, and 0x80 for any other value. No other record is touched.
- R5: A read on a non-fresh log whose first free slot is i≥1 returns record i-1's payload with empty=0.
- R6: A read on a non-fresh log where every marker matches returns the last record's payload with empty=0.
- R7: Erase writes 0xFF to the marker byte of every record and leaves all payload bytes unchanged. A read after an erase reports empty=1.
- R8: Opcodes are 1 = append, 2 = read, 3 = erase. Opcode 0 completes with a done pulse and makes no memory access.
- R9: A command is taken when cmd_valid and cmd_ready are both high. cmd_ready stays low from the cycle after acceptance until done. done is high for exactly one cycle per command.
- R10: mem_we and mem_re are one-cycle pulses that are never high together. Each is raised only if mem_ready was high on the preceding cycle. A new access starts only after the previous one has completed.
- R11: After reset, cmd_ready is 1 and done, mem_we and mem_re are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode (0 no-op, 1 append, 2 read, 3 erase) |
| cmd_payload | input | 56 | Payload to append |
| cmd_ready | output | 1 | Block idle, command can be taken |
| done | output | 1 | One-cycle completion pulse |
| empty | output | 1 | Log empty; meaningful when a read completes |
| rd_payload | output | 56 | Payload of the latest record after a non-empty read |
| mem_addr | output | 10 | Store byte address |
| mem_wdata | output | 8 | Store write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Store read data, valid the cycle after mem_re |
| mem_ready | input | 1 | Store can accept a strobe |

## Verification
The assertions check the memory-port discipline on every cycle: single-cycle strobes, no overlap, a strobe only after ready, and one access at a time. They also check the command handshake timing, and that any non-erase write to address 0 carries 0x00 or 0x80. Slot selection cannot be seen by a per-cycle property. This covers the first mismatching marker, rollover inversion, the last-record rule, erase preserving payloads and byte placement, so only the bench scenarios can show it. The bench compares the whole store image and the returned payload against a model of the log after each command.

// File: rtl/ring_log_pkg.sv
package ring_log_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_APPEND = 2'd1,
    OP_READ   = 2'd2,
    OP_ERASE  = 2'd3
  } log_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REF,
    S_SCAN,
    S_LAST,
    S_WR,
    S_RD,
    S_ERASE,
    S_FIN
  } seq_state_e;

  localparam logic [7:0] MARK_FRESH = 8'hFF;
  localparam logic [7:0] MARK_HI    = 8'h80;
  localparam logic [7:0] MARK_LO    = 8'h00;

  // Marker for a wrap: 0x80 turns into 0x00, anything else into 0x80
  function automatic logic [7:0] flip_mark(input logic [7:0] cur);
    return (cur == MARK_HI) ? MARK_LO : MARK_HI;
  endfunction

endpackage

// File: rtl/ring_log_port.sv
module ring_log_port #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          acc_done,
  output logic [7:0]    acc_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready
);

  typedef enum logic [1:0] {E_IDLE, E_WAIT, E_STRB, E_CAPT} eng_state_e;

  eng_state_e st;
  logic       wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      wr_q      <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      acc_done  <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (req) begin
            wr_q      <= req_wr;
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
            st        <= E_WAIT;
          end
        end
        E_WAIT: begin
          if (mem_ready) begin
            mem_we <= wr_q;
            mem_re <= !wr_q;
            st     <= E_STRB;
          end
        end
        E_STRB: begin
          mem_we <= 1'b0;
          mem_re <= 1'b0;
          if (wr_q) begin
            acc_done <= 1'b1;
            st       <= E_IDLE;
          end else begin
            st <= E_CAPT;
          end
        end
        default: begin
          acc_rdata <= mem_rdata;
          acc_done  <= 1'b1;
          st        <= E_IDLE;
        end
      endcase
    end
  end

  // R10
  strobe_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> $past(mem_ready));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |=> !(mem_we || mem_re));
  // R10
  single_flight_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> (st == E_IDLE));

endmodule

// File: rtl/ring_log_lanes.sv
module ring_log_lanes #(
  parameter int REC_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [8*(REC_BYTES-1)-1:0] pay_in,
  input  logic [$clog2(REC_BYTES)-1:0] sel,
  input  logic                     cap,
  input  logic [7:0]               byte_in,
  output logic [7:0]               byte_out,
  output logic [8*(REC_BYTES-1)-1:0] pay_out
);

  localparam int NLANE = REC_BYTES - 1;
  localparam int PW    = 8 * NLANE;
  localparam int KW    = $clog2(REC_BYTES);

  logic [PW-1:0] wr_q;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= '0;
    else if (load) wr_q <= pay_in;
  end

  // Byte index 0 is the marker; payload lanes occupy indices 1..NLANE
  always_comb begin
    byte_out = '0;
    for (int j = 0; j < NLANE; j++) begin
      if (sel == KW'(j + 1)) byte_out = wr_q[j*8 +: 8];
    end
  end

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (cap && sel == KW'(j + 1)) q <= byte_in;
    end
    assign pay_out[j*8 +: 8] = q;
  end

endmodule

// File: rtl/ring_log_ctrl.sv
module ring_log_ctrl
  import ring_log_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int REC_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  output logic                         cmd_ready,
  output logic                         done,
  output logic                         empty,
  output logic                         accept,
  output logic [$clog2(REC_BYTES)-1:0] lane_sel,
  output logic                         lane_cap,
  input  logic [7:0]                   lane_byte,
  output logic                         acc_req,
  output logic                         acc_wr,
  output logic [$clog2(MEM_BYTES)-1:0] acc_addr,
  output logic [7:0]                   acc_wdata,
  input  logic                         acc_done,
  input  logic [7:0]                   acc_rdata
);

  localparam int NREC  = MEM_BYTES / REC_BYTES;
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int IW    = $clog2(NREC);
  localparam int KW    = $clog2(REC_BYTES);
  localparam logic [IW-1:0] LAST_REC  = IW'(NREC - 1);
  localparam logic [KW-1:0] LAST_BYTE = KW'(REC_BYTES - 1);

  seq_state_e    state;
  log_op_e       op_q;
  logic          pend;
  logic [7:0]    ref_q;
  logic [7:0]    mark_q;
  logic [IW-1:0] idx;
  logic [IW-1:0] base_q;
  logic [KW-1:0] k;
  logic          ready_q;
  logic          done_q;
  logic          empty_q;

  logic          acc_state;
  logic          scan_hit;
  logic          scan_end;
  logic [IW-1:0] slot;

  assign cmd_ready = ready_q;
  assign done      = done_q;
  assign empty     = empty_q;
  assign accept    = (state == S_IDLE) && cmd_valid && ready_q;
  assign lane_sel  = k;
  assign lane_cap  = (state == S_RD) && acc_done;

  assign acc_state = (state == S_REF) || (state == S_SCAN) || (state == S_LAST) ||
                     (state == S_WR)  || (state == S_RD)   || (state == S_ERASE);
  assign acc_req   = acc_state && !pend;
  assign acc_wr    = (state == S_WR) || (state == S_ERASE);

  // Scan result: first mismatching marker, or rollover to record 0
  assign scan_hit = acc_done && (acc_rdata != ref_q);
  assign scan_end = (state == S_SCAN) && acc_done && (scan_hit || idx == LAST_REC);
  assign slot     = scan_hit ? idx : '0;

  always_comb begin
    case (state)
      S_SCAN, S_ERASE: acc_addr = AW'(idx) * AW'(REC_BYTES);
      S_LAST:          acc_addr = AW'(LAST_REC) * AW'(REC_BYTES);
      S_WR, S_RD:      acc_addr = AW'(base_q) * AW'(REC_BYTES) + AW'(k);
      default:         acc_addr = '0;
    endcase
  end

  always_comb begin
    if (state == S_ERASE)  acc_wdata = MARK_FRESH;
    else if (k == '0)      acc_wdata = mark_q;
    else                   acc_wdata = lane_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      op_q    <= OP_NOP;
      pend    <= 1'b0;
      ref_q   <= '0;
      mark_q  <= '0;
      idx     <= '0;
      base_q  <= '0;
      k       <= '0;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (acc_done)     pend <= 1'b0;
      else if (acc_req) pend <= 1'b1;

      case (state)
        S_IDLE: begin
          if (accept) begin
            op_q    <= log_op_e'(cmd_op);
            ready_q <= 1'b0;
            idx     <= '0;
            k       <= '0;
            case (log_op_e'(cmd_op))
              OP_APPEND, OP_READ: state <= S_REF;
              OP_ERASE:           state <= S_ERASE;
              default: begin
                empty_q <= 1'b0;
                state   <= S_FIN;
              end
            endcase
          end
        end

        S_REF: begin
          if (acc_done) begin
            ref_q <= acc_rdata;
            if (acc_rdata == MARK_FRESH) begin
              if (op_q == OP_APPEND) begin
                base_q <= '0;
                mark_q <= flip_mark(acc_rdata);
                k      <= '0;
                state  <= S_WR;
              end else begin
                empty_q <= 1'b1;
                state   <= S_FIN;
              end
            end else begin
              idx   <= IW'(1);
              state <= S_SCAN;
            end
          end
        end

        S_SCAN: begin
          if (scan_end) begin
            if (op_q == OP_APPEND) begin
              base_q <= slot;
              mark_q <= (slot == '0) ? flip_mark(ref_q) : ref_q;
              k      <= '0;
              state  <= S_WR;
            end else if (slot != '0) begin
              base_q <= slot - 1'b1;
              k      <= KW'(1);
              state  <= S_RD;
            end else begin
              state <= S_LAST;
            end
          end else if (acc_done) begin
            idx <= idx + 1'b1;
          end
        end

        S_LAST: begin
          if (acc_done) begin
            if (acc_rdata == ref_q) begin
              base_q <= LAST_REC;
              k      <= KW'(1);
              state  <= S_RD;
            end else begin
              empty_q <= 1'b1;
              state   <= S_FIN;
            end
          end
        end

        S_WR, S_RD: begin
          if (acc_done) begin
            if (k == LAST_BYTE) begin
              empty_q <= 1'b0;
              state   <= S_FIN;
            end else begin
              k <= k + 1'b1;
            end
          end
        end

        S_ERASE: begin
          if (acc_done) begin
            if (idx == LAST_REC) begin
              empty_q <= 1'b0;
              state   <= S_FIN;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end

        default: begin
          state   <= S_IDLE;
          ready_q <= 1'b1;
          done_q  <= 1'b1;
        end
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R8
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == 2'd0) |=> !acc_req);

endmodule

// File: rtl/ring_log.sv
module ring_log #(
  parameter int MEM_BYTES = 1024,
  parameter int REC_BYTES = 8,
  localparam int PW = 8 * (REC_BYTES - 1),
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [PW-1:0] cmd_payload,
  output logic          cmd_ready,
  output logic          done,
  output logic          empty,
  output logic [PW-1:0] rd_payload,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready
);

  localparam int KW = $clog2(REC_BYTES);

  logic          accept;
  logic [KW-1:0] lane_sel;
  logic          lane_cap;
  logic [7:0]    lane_byte;
  logic          acc_req;
  logic          acc_wr;
  logic [AW-1:0] acc_addr;
  logic [7:0]    acc_wdata;
  logic          acc_done;
  logic [7:0]    acc_rdata;

  ring_log_ctrl #(.MEM_BYTES(MEM_BYTES), .REC_BYTES(REC_BYTES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .done      (done),
    .empty     (empty),
    .accept    (accept),
    .lane_sel  (lane_sel),
    .lane_cap  (lane_cap),
    .lane_byte (lane_byte),
    .acc_req   (acc_req),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_done  (acc_done),
    .acc_rdata (acc_rdata)
  );

  ring_log_lanes #(.REC_BYTES(REC_BYTES)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .pay_in   (cmd_payload),
    .sel      (lane_sel),
    .cap      (lane_cap),
    .byte_in  (acc_rdata),
    .byte_out (lane_byte),
    .pay_out  (rd_payload)
  );

  ring_log_port #(.AW(AW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .req       (acc_req),
    .req_wr    (acc_wr),
    .req_addr  (acc_addr),
    .req_wdata (acc_wdata),
    .acc_done  (acc_done),
    .acc_rdata (acc_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready)
  );

  // R4
  wrap_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_addr == '0 && mem_wdata != 8'hFF) |->
      (mem_wdata == 8'h80 || mem_wdata == 8'h00));

endmodule

// File: tb/ring_log_test.sv
module ring_log_test;
  localparam int MEMB = 1024;
  localparam int RB   = 8;
  localparam int NR   = MEMB / RB;
  localparam int PW   = 8 * (RB - 1);
  localparam int AW   = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [PW-1:0] cmd_payload;
  logic          cmd_ready, done, empty;
  logic [PW-1:0] rd_payload;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_we, mem_re;
  logic [7:0]    mem_rdata;
  logic          mem_ready;

  ring_log uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_payload(cmd_payload), .cmd_ready(cmd_ready), .done(done),
    .empty(empty), .rd_payload(rd_payload), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // External store model with random write-busy time
  logic [7:0] mem  [0:MEMB-1];
  logic [7:0] snap [0:MEMB-1];
  int busy = 0;
  int strobes = 0;
  int port_viol = 0;
  logic prev_ready = 1'b1;
  assign mem_ready = (busy == 0);

  always @(posedge clk) begin
    if (busy != 0) busy <= busy - 1;
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      busy <= $urandom_range(0, 3);
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_we || mem_re) strobes <= strobes + 1;
    if ((mem_we || mem_re) && !prev_ready) port_viol <= port_viol + 1;
    if (mem_we && mem_re) port_viol <= port_viol + 1;
    prev_ready <= mem_ready;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int free_slot();
    logic [7:0] r = mem[0];
    if (r == 8'hFF) return 0;
    for (int i = 1; i < NR; i++) if (mem[i*RB] != r) return i;
    return 0;
  endfunction

  function automatic int latest();
    logic [7:0] r = mem[0];
    int f;
    if (r == 8'hFF) return -1;
    f = free_slot();
    if (f != 0) return f - 1;
    if (mem[(NR-1)*RB] == r) return NR - 1;
    return -1;
  endfunction

  function automatic logic [PW-1:0] rec_payload(input int i);
    logic [PW-1:0] p;
    for (int j = 0; j < RB - 1; j++) p[j*8 +: 8] = mem[i*RB + 1 + j];
    return p;
  endfunction

  function automatic logic [PW-1:0] rnd_payload();
    return PW'({$urandom(), $urandom()});
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [PW-1:0] pl,
                         output bit got_empty, output logic [PW-1:0] got_pl);
    int n;
    @(negedge clk);
    n = 0;
    while (!cmd_ready && n < 1000) begin @(negedge clk); n++; end
    cmd_valid = 1'b1; cmd_op = op; cmd_payload = pl;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R9", "cmd_ready after accept", cmd_ready, 0);
    n = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    if (!done) chk(1'b0, "R9", "done never seen", 0, 1);
    got_empty = empty;
    got_pl = rd_payload;
    @(negedge clk);
    chk(!done, "R9", "done pulse width", done, 0);
  endtask

  task automatic cmp_mem(input string req, input string what);
    int bad = -1;
    for (int a = MEMB - 1; a >= 0; a--) if (mem[a] !== snap[a]) bad = a;
    if (bad < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, {what, " byte mismatch"}, {54'd0, bad[9:0]}, 0);
  endtask

  task automatic do_append(input logic [PW-1:0] pl, input string req);
    int slot;
    logic [7:0] r, mk;
    bit e; logic [PW-1:0] p;
    slot = free_slot();
    r = mem[0];
    mk = (slot == 0) ? ((r == 8'h80) ? 8'h00 : 8'h80) : r;
    for (int a = 0; a < MEMB; a++) snap[a] = mem[a];
    snap[slot*RB] = mk;
    for (int j = 0; j < RB - 1; j++) snap[slot*RB + 1 + j] = pl[j*8 +: 8];
    run_cmd(2'd1, pl, e, p);
    cmp_mem(req, "append image");
  endtask

  task automatic do_read(input string req);
    int lat;
    logic [PW-1:0] exp_pl, p;
    bit e;
    lat = latest();
    exp_pl = (lat >= 0) ? rec_payload(lat) : '0;
    run_cmd(2'd2, '0, e, p);
    if (lat < 0) chk(e == 1'b1, req, "empty on read", e, 1);
    else begin
      chk(e == 1'b0, req, "empty on read", e, 0);
      chk(p == exp_pl, req, "read payload", p, exp_pl);
    end
  endtask

  task automatic do_erase();
    bit e; logic [PW-1:0] p;
    for (int a = 0; a < MEMB; a++) snap[a] = mem[a];
    for (int i = 0; i < NR; i++) snap[i*RB] = 8'hFF;
    run_cmd(2'd3, '0, e, p);
    cmp_mem("R7", "erase image");
  endtask

  task automatic do_nop();
    int s0;
    bit e; logic [PW-1:0] p;
    s0 = strobes;
    for (int a = 0; a < MEMB; a++) snap[a] = mem[a];
    run_cmd(2'd0, rnd_payload(), e, p);
    chk(strobes == s0, "R8", "no-op strobes", strobes - s0, 0);
    cmp_mem("R8", "no-op image");
  endtask

  // Records below b carry marker mk, the rest differ from it
  task automatic preload(input logic [7:0] mk, input int b);
    logic [7:0] v;
    @(negedge clk);
    for (int a = 0; a < MEMB; a++) mem[a] = 8'($urandom());
    for (int i = 0; i < NR; i++) begin
      v = 8'($urandom());
      if (v == mk) v = ~mk;
      mem[i*RB] = (i < b) ? mk : v;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog: actual cycles 190000 expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd5150);
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_payload = '0;
    for (int a = 0; a < MEMB; a++) mem[a] = 8'($urandom());
    for (int i = 0; i < NR; i++) mem[i*RB] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(cmd_ready == 1'b1, "R11", "cmd_ready", cmd_ready, 1);
    chk(done == 1'b0, "R11", "done", done, 0);
    chk(!mem_we && !mem_re, "R11", "strobes", {mem_we, mem_re}, 0);

    // R2 fresh store
    do_read("R2");
    do_append(rnd_payload(), "R2");
    chk(mem[0] == 8'h80, "R2", "fresh marker", mem[0], 8'h80);
    do_read("R5");
    // R1 R3 consecutive appends with reads
    for (int n = 0; n < 5; n++) begin
      do_append(rnd_payload(), "R1 R3");
      do_read("R5");
    end

    // R6 then R4: every marker matches 0x80
    preload(8'h80, NR);
    do_read("R6");
    do_append(rnd_payload(), "R4");
    chk(mem[0] == 8'h00, "R4", "wrap marker from 0x80", mem[0], 8'h00);
    do_read("R5");
    do_append(rnd_payload(), "R3");

    preload(8'h00, NR);
    do_append(rnd_payload(), "R4");
    chk(mem[0] == 8'h80, "R4", "wrap marker from 0x00", mem[0], 8'h80);

    preload(8'h5A, NR);
    do_read("R6");
    do_append(rnd_payload(), "R4");
    chk(mem[0] == 8'h80, "R4", "wrap marker from 0x5A", mem[0], 8'h80);

    // R3 boundary deep in the ring and at the last record
    preload(8'h5A, 77);
    do_read("R5");
    do_append(rnd_payload(), "R3");
    chk(mem[77*RB] == 8'h5A, "R3", "copied marker", mem[77*RB], 8'h5A);
    preload(8'h00, NR - 1);
    do_read("R5");
    do_append(rnd_payload(), "R3");
    do_read("R6");

    do_nop();
    do_erase();
    do_read("R7");

    // Random mix
    for (int n = 0; n < 40; n++) begin
      int sel, kind;
      if ($urandom_range(0, 3) == 0) begin
        kind = $urandom_range(0, 2);
        preload(kind == 0 ? 8'h80 : (kind == 1 ? 8'h00 : 8'($urandom())),
                $urandom_range(1, NR));
      end
      sel = $urandom_range(0, 9);
      if (sel < 4)      do_append(rnd_payload(), "R3");
      else if (sel < 8) do_read("R5");
      else if (sel < 9) do_nop();
      else begin do_erase(); do_read("R7"); end
    end

    chk(port_viol == 0, "R10", "strobe discipline violations", port_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule